// File: doc/BRIEF.md
# Two-Wire Bus Master Register Front End

This block is the software-visible register file of a two-wire serial bus master. A host reaches it over a simple word-indexed read/write port and sets up clock dividers, bus options, a target address and up to eight bytes of outgoing data. A write to the command word starts a transfer. The block then raises a one-cycle start strobe and presents the decoded command to a separate bus sequencer, which carries out the transfer on the wires.

When the sequencer finishes, it reports an error code and any received bytes. The block records the outcome in a write-one-to-clear status word, stores the received bytes and clears its busy indication. A single interrupt line is driven from the status bits that the mask allows. The usual setup enables only the completion bit, and software reads the error bits that are set beside it.

Register word indices (byte offset divided by four): 0 standard/fast clock, 1 high-speed clock, 2 bus configuration, 3 command, 4 target address, 5 data low, 6 data high, 7 status, 8 interrupt mask, 9 busy.

Top module: `twi_regfile`

## Requirements
- R1: After reset both clock words read 0x301F, the configuration word reads 0x3302, and the mask, status, busy, address and data words read 0. The irq output is 0.
- R2: Only defined fields are stored. Clock words keep bits 15:12 and 9:0 (mask 0xF3FF), configuration keeps bits 15:4 and 1:0 (mask 0xFFF3), the address keeps bits 9:0 and the mask keeps bits 4:0. The configuration and clock values appear on their output ports.
- R3: A command write while idle gives a start strobe that lasts exactly one cycle, in the cycle after the write. The strobe presents the type from command bits 9:8 (0 write, 1 read, 2 write-then-read), the write count minus one from bits 6:4 and the read count minus one from bits 2:0. The busy word reads 1 until completion.
- R4: A completion report while busy clears busy and sets status bit 0. In the same update, the four sequencer error inputs set status bits 1 (lost arbitration), 2 (no response), 3 (data collision) and 4 (bus busy). A completion report while idle has no effect.
- R5: Writing the status word clears exactly the bits written as 1. The other bits are left unchanged.
- R6: irq is 1 exactly when some status bit and its mask bit are both 1. irq follows the status and mask registers one cycle later.
- R7: A command write while busy is ignored. No strobe is raised, the command fields do not change, and status bit 4 is set.
- R8: tx_data is {data high, data low}, with the last byte to send in bits 7:0. Bytes at and above the write count are presented as zero.
- R9: When a read or write-then-read transfer completes with no error, the data words take the received bytes, with the first byte received in data-low bits 7:0. Bytes at and above the read count are zeroed. A failed or write-only transfer leaves the data words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read request |
| cmd_start | output | 1 | One-cycle transfer start strobe |
| cmd_type | output | 2 | Transfer type |
| cmd_wlen_m1 | output | 3 | Write byte count minus one |
| cmd_rlen_m1 | output | 3 | Read byte count minus one |
| slave_addr | output | 10 | Target address |
| tx_data | output | 64 | Outgoing bytes, right aligned and masked to the write count |
| cfg_word | output | 16 | Bus configuration word |
| std_clk_word | output | 16 | Standard/fast clock word |
| hs_clk_word | output | 16 | High-speed clock word |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_err | input | 4 | Error code: bit0 lost arbitration, bit1 no response, bit2 collision, bit3 bus busy |
| rx_data | input | 64 | Received bytes, first byte in bits 7:0 |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check the following on every cycle: the start strobe lasts one cycle and coincides with busy, a completion report always drops busy and raises the done bit, a rejected command neither strobes nor alters the command fields, written-one status bits clear, irq stays low when no enabled bit is set, and the data words hold unless loaded or written. Three things only the bench scenarios can show: that the error code lands in the correct status bit positions, that the byte masking for each transfer length and type is right, and that the mask selects which outcome raises irq.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] RI_CLK_STD = 4'd0;
  localparam logic [IDX_W-1:0] RI_CLK_HS  = 4'd1;
  localparam logic [IDX_W-1:0] RI_CFG     = 4'd2;
  localparam logic [IDX_W-1:0] RI_CMD     = 4'd3;
  localparam logic [IDX_W-1:0] RI_SLV     = 4'd4;
  localparam logic [IDX_W-1:0] RI_DLO     = 4'd5;
  localparam logic [IDX_W-1:0] RI_DHI     = 4'd6;
  localparam logic [IDX_W-1:0] RI_STS     = 4'd7;
  localparam logic [IDX_W-1:0] RI_MSK     = 4'd8;
  localparam logic [IDX_W-1:0] RI_BUSY    = 4'd9;

  localparam int STS_W        = 5;
  localparam int STS_DONE     = 0;
  localparam int STS_BUSBUSY  = 4;

  localparam int HALF_W = 16;
  localparam logic [HALF_W-1:0] CLK_RST   = 16'h301F;
  localparam logic [HALF_W-1:0] CLK_WMASK = 16'hF3FF;
  localparam logic [HALF_W-1:0] CFG_RST   = 16'h3302;
  localparam logic [HALF_W-1:0] CFG_WMASK = 16'hFFF3;

  typedef enum logic [1:0] {
    XFER_WR   = 2'd0,
    XFER_RD   = 2'd1,
    XFER_WRRD = 2'd2
  } xfer_e;
endpackage

// File: rtl/twi_cfg_bank.sv
module twi_cfg_bank
  import twi_pkg::*;
#(
  parameter int SLV_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [HALF_W-1:0]    wdata,
  output logic [HALF_W-1:0]    clk_std,
  output logic [HALF_W-1:0]    clk_hs,
  output logic [HALF_W-1:0]    cfg,
  output logic [SLV_W-1:0]     slv,
  output logic [STS_W-1:0]     msk
);
  localparam int NCLK = 2;
  logic [NCLK-1:0][HALF_W-1:0] clk_q;

  for (genvar g = 0; g < NCLK; g++) begin : g_clk
    localparam logic [IDX_W-1:0] MY_IDX = (g == 0) ? RI_CLK_STD : RI_CLK_HS;
    logic [HALF_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                            q <= CLK_RST;
      else if (wr_en && wr_idx == MY_IDX) q <= wdata & CLK_WMASK;
    end
    assign clk_q[g] = q;
  end

  assign clk_std = clk_q[0];
  assign clk_hs  = clk_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RST;
      slv <= '0;
      msk <= '0;
    end else if (wr_en) begin
      if (wr_idx == RI_CFG) cfg <= wdata & CFG_WMASK;
      if (wr_idx == RI_SLV) slv <= wdata[SLV_W-1:0];
      if (wr_idx == RI_MSK) msk <= wdata[STS_W-1:0];
    end
  end

  // R2: undefined configuration bits never become set
  a_r2_cfg_holes: assert property (@(posedge clk) disable iff (rst)
    (cfg & ~CFG_WMASK) == '0);
endmodule

// File: rtl/twi_cmd_ctl.sv
module twi_cmd_ctl
  import twi_pkg::*;
#(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [1:0]    wr_type,
  input  logic [LW-1:0] wr_wl,
  input  logic [LW-1:0] wr_rl,
  input  logic          seq_done,
  output logic          busy_q,
  output logic          start_q,
  output logic [1:0]    type_q,
  output logic [LW-1:0] wl_q,
  output logic [LW-1:0] rl_q,
  output logic          fin,
  output logic          reject
);
  logic accept;
  assign accept = cmd_wr && !busy_q;
  assign reject = cmd_wr && busy_q;
  assign fin    = seq_done && busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      type_q  <= '0;
      wl_q    <= '0;
      rl_q    <= '0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        start_q <= 1'b1;
        type_q  <= wr_type;
        wl_q    <= wr_wl;
        rl_q    <= wr_rl;
      end else if (fin) begin
        busy_q  <= 1'b0;
      end
    end
  end

  a_r3_one_shot: assert property (@(posedge clk) disable iff (rst)
    start_q |=> !start_q);
  a_r3_strobe_busy: assert property (@(posedge clk) disable iff (rst)
    start_q |-> busy_q);
  a_r4_fin_idle: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy_q);
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    reject |=> (!start_q && $stable(type_q) && $stable(wl_q) && $stable(rl_q)));
endmodule

// File: rtl/twi_status.sv
module twi_status
  import twi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [STS_W-1:0] clr_vec,
  input  logic [STS_W-1:0] msk,
  output logic [STS_W-1:0] sts_q,
  output logic             irq_q
);
  logic [STS_W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_eff) | set_vec;
      irq_q <= |(sts_q & msk);
    end
  end

  a_r4_done_sets: assert property (@(posedge clk) disable iff (rst)
    set_vec[STS_DONE] |=> sts_q[STS_DONE]);
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (clr_en && ((clr_vec & ~set_vec) != '0)) |=>
      ((sts_q & $past(clr_vec & ~set_vec)) == '0));
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((sts_q & msk) == '0) |=> !irq_q);
endmodule

// File: rtl/twi_data_bank.sv
module twi_data_bank
  import twi_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NBYTES = 8,
  parameter int LW     = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [DW-1:0]         wdata,
  input  logic                  load_en,
  input  logic [LW-1:0]         rlen_m1,
  input  logic [LW-1:0]         wlen_m1,
  input  logic [8*NBYTES-1:0]   rx_data,
  output logic [8*NBYTES-1:0]   words,
  output logic [8*NBYTES-1:0]   tx_data
);
  localparam int NW = (8 * NBYTES) / DW;
  logic [8*NBYTES-1:0] rx_kept;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign rx_kept[8*b +: 8] = (rlen_m1 >= LW'(b)) ? rx_data[8*b +: 8] : 8'h00;
    assign tx_data[8*b +: 8] = (wlen_m1 >= LW'(b)) ? words[8*b +: 8]   : 8'h00;
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam logic [IDX_W-1:0] MY_IDX = RI_DLO + IDX_W'(w);
    always_ff @(posedge clk) begin
      if (rst)                            words[DW*w +: DW] <= '0;
      else if (load_en)                   words[DW*w +: DW] <= rx_kept[DW*w +: DW];
      else if (wr_en && wr_idx == MY_IDX) words[DW*w +: DW] <= wdata;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !wr_en) |=> $stable(words));
  a_r8_top_zero: assert property (@(posedge clk) disable iff (rst)
    (wlen_m1 != LW'(NBYTES-1)) |-> (tx_data[8*NBYTES-1 -: 8] == 8'h00));
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile
  import twi_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NBYTES = 8,
  parameter int SLV_W  = 10,
  parameter int ERR_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [3:0]          bus_idx,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                cmd_start,
  output logic [1:0]          cmd_type,
  output logic [2:0]          cmd_wlen_m1,
  output logic [2:0]          cmd_rlen_m1,
  output logic [9:0]          slave_addr,
  output logic [63:0]         tx_data,
  output logic [15:0]         cfg_word,
  output logic [15:0]         std_clk_word,
  output logic [15:0]         hs_clk_word,
  input  logic                seq_done,
  input  logic [3:0]          seq_err,
  input  logic [63:0]         rx_data,
  output logic                irq
);
  localparam int LW = $clog2(NBYTES);

  logic wr_en;
  assign wr_en = bus_en && bus_we;

  logic [STS_W-1:0] msk, sts;
  logic busy, fin, reject;
  logic [8*NBYTES-1:0] words;

  twi_cfg_bank #(.SLV_W(SLV_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(bus_idx),
    .wdata(bus_wdata[HALF_W-1:0]),
    .clk_std(std_clk_word), .clk_hs(hs_clk_word), .cfg(cfg_word),
    .slv(slave_addr), .msk(msk)
  );

  twi_cmd_ctl #(.LW(LW)) u_cmd (
    .clk(clk), .rst(rst), .cmd_wr(wr_en && bus_idx == RI_CMD),
    .wr_type(bus_wdata[9:8]), .wr_wl(bus_wdata[4 +: LW]), .wr_rl(bus_wdata[0 +: LW]),
    .seq_done(seq_done), .busy_q(busy), .start_q(cmd_start),
    .type_q(cmd_type), .wl_q(cmd_wlen_m1), .rl_q(cmd_rlen_m1),
    .fin(fin), .reject(reject)
  );

  logic [STS_W-1:0] set_vec;
  always_comb begin
    set_vec = '0;
    if (fin) set_vec = {seq_err, 1'b1};
    if (reject) set_vec[STS_BUSBUSY] = 1'b1;
  end

  twi_status u_sts (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_en(wr_en && bus_idx == RI_STS), .clr_vec(bus_wdata[STS_W-1:0]),
    .msk(msk), .sts_q(sts), .irq_q(irq)
  );

  logic load_en;
  assign load_en = fin && (seq_err == '0) && (cmd_type != XFER_WR);

  twi_data_bank #(.DW(DW), .NBYTES(NBYTES)) u_dat (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(bus_idx), .wdata(bus_wdata),
    .load_en(load_en), .rlen_m1(cmd_rlen_m1), .wlen_m1(cmd_wlen_m1),
    .rx_data(rx_data), .words(words), .tx_data(tx_data)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_idx)
      RI_CLK_STD: rd_mux[HALF_W-1:0] = std_clk_word;
      RI_CLK_HS:  rd_mux[HALF_W-1:0] = hs_clk_word;
      RI_CFG:     rd_mux[HALF_W-1:0] = cfg_word;
      RI_CMD:     rd_mux[9:0] = {cmd_type, 1'b0, cmd_wlen_m1, 1'b0, cmd_rlen_m1};
      RI_SLV:     rd_mux[SLV_W-1:0] = slave_addr;
      RI_DLO:     rd_mux = words[31:0];
      RI_DHI:     rd_mux = words[63:32];
      RI_STS:     rd_mux[STS_W-1:0] = sts;
      RI_MSK:     rd_mux[STS_W-1:0] = msk;
      RI_BUSY:    rd_mux[0] = busy;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_mux;
  end

  // R4: a finished transfer is always recorded with the done flag
  a_r4_fin_recorded: assert property (@(posedge clk) disable iff (rst)
    fin |=> (sts[STS_DONE] && !busy));
  // R7: a rejected command leaves its mark in the bus-busy flag
  a_r7_flagged: assert property (@(posedge clk) disable iff (rst)
    reject |=> sts[STS_BUSBUSY]);
endmodule

// File: tb/test_twi_regfile.sv
module test_twi_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_idx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_start;
  logic [1:0]  cmd_type;
  logic [2:0]  cmd_wlen_m1, cmd_rlen_m1;
  logic [9:0]  slave_addr;
  logic [63:0] tx_data;
  logic [15:0] cfg_word, std_clk_word, hs_clk_word;
  logic        seq_done = 1'b0;
  logic [3:0]  seq_err = '0;
  logic [63:0] rx_data = '0;
  logic        irq;

  always #10 clk = ~clk;

  twi_regfile i_twi_regfile (.*);

  int total = 0;
  int failed = 0;

  typedef struct packed {
    logic [1:0]  typ;
    logic [2:0]  wl;
    logic [2:0]  rl;
    logic [3:0]  err;
    logic [63:0] rx;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 3'd0, 4'b0000, 64'h0},
    '{2'd0, 3'd5, 3'd0, 4'b0000, 64'h0},
    '{2'd1, 3'd0, 3'd2, 4'b0000, 64'hAABBCCDD_EEFF0011},
    '{2'd2, 3'd7, 3'd7, 4'b0000, 64'h01234567_89ABCDEF},
    '{2'd1, 3'd0, 3'd3, 4'b0010, 64'hFFFFFFFF_FFFFFFFF},
    '{2'd0, 3'd3, 3'd0, 4'b1000, 64'h0}
  };

  localparam logic [31:0] PAT_LO = 32'h55667788;
  localparam logic [31:0] PAT_HI = 32'h11223344;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_idx = idx; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_idx = idx;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic respond(input logic [3:0] e, input logic [63:0] r);
    @(negedge clk);
    seq_done = 1'b1; seq_err = e; rx_data = r;
    @(negedge clk);
    seq_done = 1'b0; seq_err = '0;
  endtask

  function automatic logic [63:0] keep(input logic [63:0] v, input int n);
    logic [63:0] o = v;
    for (int b = 0; b < 8; b++) if (b >= n) o[8*b +: 8] = 8'h00;
    return o;
  endfunction

  initial begin
    #(20 * 200000);
    total++; failed++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [63:0] exp_words;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_read(4'd0, rd); chk("R1 std clk", rd, 32'h301F);
    bus_read(4'd1, rd); chk("R1 hs clk", rd, 32'h301F);
    bus_read(4'd2, rd); chk("R1 cfg", rd, 32'h3302);
    bus_read(4'd7, rd); chk("R1 status", rd, 0);
    bus_read(4'd8, rd); chk("R1 mask", rd, 0);
    bus_read(4'd9, rd); chk("R1 busy", rd, 0);
    bus_read(4'd5, rd); chk("R1 data lo", rd, 0);
    chk("R1 irq", irq, 0);

    // R2: field masking
    bus_write(4'd2, 32'hFFFF_FFFF);
    bus_read(4'd2, rd); chk("R2 cfg mask", rd, 32'hFFF3);
    chk("R2 cfg port", cfg_word, 16'hFFF3);
    bus_write(4'd0, 32'h0000_FFFF);
    bus_read(4'd0, rd); chk("R2 clk mask", rd, 32'hF3FF);
    chk("R2 hs untouched", hs_clk_word, 16'h301F);
    bus_write(4'd4, 32'hFFFF_FFFF);
    bus_read(4'd4, rd); chk("R2 addr mask", rd, 32'h3FF);
    chk("R2 addr port", slave_addr, 10'h3FF);
    bus_write(4'd8, 32'hFF);
    bus_read(4'd8, rd); chk("R2 mask reg", rd, 32'h1F);
    bus_write(4'd8, 32'h0);

    // table of transfers
    for (int i = 0; i < NV; i++) begin
      bus_write(4'd5, PAT_LO);
      bus_write(4'd6, PAT_HI);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_idx = 4'd3;
      bus_wdata = {22'd0, VECS[i].typ, 1'b0, VECS[i].wl, 1'b0, VECS[i].rl};
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
      chk("R3 strobe", cmd_start, 1);
      chk("R3 type", cmd_type, VECS[i].typ);
      chk("R3 wlen", cmd_wlen_m1, VECS[i].wl);
      chk("R3 rlen", cmd_rlen_m1, VECS[i].rl);
      chk("R8 tx", tx_data, keep({PAT_HI, PAT_LO}, int'(VECS[i].wl) + 1));
      @(negedge clk);
      chk("R3 strobe one cycle", cmd_start, 0);
      bus_read(4'd9, rd); chk("R3 busy", rd, 1);
      respond(VECS[i].err, VECS[i].rx);
      bus_read(4'd9, rd); chk("R4 busy cleared", rd, 0);
      bus_read(4'd7, rd); chk("R4 status", rd, {27'd0, VECS[i].err, 1'b1});
      if (VECS[i].err == 0 && VECS[i].typ != 2'd0)
        exp_words = keep(VECS[i].rx, int'(VECS[i].rl) + 1);
      else
        exp_words = {PAT_HI, PAT_LO};
      bus_read(4'd5, rd); chk("R9 data lo", rd, exp_words[31:0]);
      bus_read(4'd6, rd); chk("R9 data hi", rd, exp_words[63:32]);
      bus_write(4'd7, 32'h1F);
      bus_read(4'd7, rd); chk("R5 clear all", rd, 0);
    end

    // R6 and R5: mask selects the interrupt, partial clear
    bus_write(4'd8, 32'h01);
    bus_write(4'd3, 32'h0000_0000);
    respond(4'b0010, '0);
    @(negedge clk);
    chk("R6 irq on done", irq, 1);
    bus_write(4'd7, 32'h01);
    @(negedge clk);
    bus_read(4'd7, rd); chk("R5 partial clear", rd, 32'h04);
    chk("R6 irq masked off", irq, 0);
    bus_write(4'd8, 32'h04);
    @(negedge clk);
    chk("R6 irq via error mask", irq, 1);
    bus_write(4'd7, 32'h1F);
    @(negedge clk);
    chk("R6 irq after clear", irq, 0);
    bus_write(4'd8, 32'h00);

    // R7: command while busy is rejected
    bus_write(4'd3, 32'h0000_0231);
    bus_write(4'd3, 32'h0000_0177);
    chk("R7 no strobe", cmd_start, 0);
    bus_read(4'd3, rd); chk("R7 cmd kept", rd, 32'h0231);
    chk("R7 type port", cmd_type, 2'd2);
    respond(4'b0000, 64'h0);
    bus_read(4'd7, rd); chk("R7 bus busy flag", rd, 32'h11);
    bus_write(4'd7, 32'h1F);

    // R4: completion while idle is ignored
    respond(4'b1111, 64'h0);
    bus_read(4'd7, rd); chk("R4 idle done ignored", rd, 0);

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule